// File: doc/BRIEF.md
# Indirect Pointer-Data Configuration Bank

This block is the host-side register file of a two-channel disk-interface controller. The host sees four byte offsets. Most configuration is reached indirectly. A pointer byte picks a channel bank and one of seven registers inside it. A 16-bit data port then reads or writes the register that the pointer selects. When the pointer's auto-advance bit is set, the index moves to the next register after every data-port access. Software can then sweep a whole bank with repeated accesses to one offset.

Three more byte registers sit beside the pointer and the data port. The first is a write-only chip test register. The second is a read-only status byte that shows the first channel's raw interrupts. The third is an interrupt mask register that also shows the second channel's raw interrupts and a board strap. Every configuration field drives an output port. Each channel has an interrupt output that is gated by its mask bit and then shaped by its polarity bit.

Top module: `ipd_cfg_bank`

## Requirements
- R1: After reset, the channel 0 bank holds these values: command base 0x1F0, control base 0x3F6, data timing 0xF5, command timing 0xDE and general byte 0x01. The channel 1 bank holds 0x170, 0x376, 0xF5, 0xDE and 0x01. In both banks the read-ahead fields are 0. The pointer, the mask and the test bits are 0.
- R2: A write to offset 1 loads the pointer byte, and a read of offset 1 returns it. Pointer bit 3 selects the bank (0 selects channel 0, 1 selects channel 1). Pointer bits 2-0 hold the index.
- R3: The data port is offset 0. Indexes 0 (command base) and 4 (control base) store and return all 16 bits. Index 1 (general byte), index 5 (data timing) and index 6 (command timing) store the low 8 bits and read back zero-extended. Each stored value appears on the matching output of its channel.
- R4: A data-port read returns 0 at index 2, index 3 and index 7. A write at index 7 changes nothing.
- R5: While pointer bit 7 is 1, every data-port read or write advances the index by one after the access. The index goes from 6 to 0 and from 7 to 0. Bits 7-3 of the pointer do not change. While bit 7 is 0, the pointer does not change.
- R6: A write at index 2 sets the low 8 bits of the 10-bit read-ahead count. A write at index 3 sets count bits 9-8 from data bits 1-0 and sets the read-ahead enable from data bit 7.
- R7: A write at index 3 with data bit 6 set gives a one-cycle pulse on that channel's FIFO clear output. The pulse comes in the cycle after the write.
- R8: The general byte bits drive these outputs: bit 7 DMA enable, bit 6 device reset, bit 5 IORDY enable, bit 4 8-bit port, bit 3 active-low interrupt, bit 2 power save, bit 1 bus-master mode and bit 0 I/O port enable.
- R9: A read of offset 2 returns {6'b0, channel 0 bus-master irq, channel 0 drive irq}. A read of offset 3 returns {3'b0, legacy strap, channel 1 bus-master irq, channel 1 drive irq, mask1, mask0}. A write to offset 3 stores only bits 1-0.
- R10: Each channel's interrupt output equals ((drive irq OR bus-master irq) AND NOT mask bit) XOR that channel's active-low bit.
- R11: A write to offset 2 loads the test register. Data bit 1 drives the legacy-mode output and data bit 0 drives the test-mode output. A read of offset 2 never returns these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe; takes precedence over host_rd |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Byte offset 0 to 3 |
| host_wdata | input | 16 | Write data; byte registers use bits 7-0 |
| host_rdata | output | 16 | Read data, 0 when no read is taking place |
| legacy_hdr_i | input | 1 | Legacy header strap |
| drv_irq_i | input | 2 | Raw drive interrupt per channel |
| bm_irq_i | input | 2 | Raw bus-master interrupt per channel |
| cmd_base_o | output | 32 | Command-block base, channel c at bits 16c+15:16c |
| ctl_base_o | output | 32 | Control-block base per channel |
| data_tim_o | output | 16 | Data-port timing byte per channel |
| cmd_tim_o | output | 16 | Command timing byte per channel |
| dma_en_o | output | 2 | DMA enable per channel |
| dev_rst_o | output | 2 | Device reset per channel |
| iordy_en_o | output | 2 | IORDY enable per channel |
| port8_o | output | 2 | 8-bit data port per channel |
| irq_act_low_o | output | 2 | Active-low interrupt per channel |
| pwr_save_o | output | 2 | Power save per channel |
| bm_mode_o | output | 2 | Bus-master mode per channel |
| io_en_o | output | 2 | I/O port enable per channel |
| ra_count_o | output | 20 | 10-bit read-ahead count per channel |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per channel |
| test_mode_o | output | 1 | Test mode from the test register |
| legacy_mode_o | output | 1 | Legacy mode from the test register |
| irq_o | output | 2 | Masked, polarity-adjusted interrupt per channel |

## Verification
The bench sweeps each bank with auto-advance set. This shows that the index order is correct, that the index wraps at 6 and at 7, and that the channel bit stays put. A second pass with auto-advance clear shows that repeated accesses stay on one register. Write sweeps with distinct data in every register would expose a mixed-up bank, a mixed-up index or a lane that does not store. Reads and writes at the unreadable indexes show the zero result and that nothing is stored. The interrupt path runs through every combination of the four raw lines under each mask value and each polarity. This sets apart mask gating, polarity inversion and the raw status views.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
   // Host byte offsets (the host map depends on these)
   localparam int OFS_DATA = 0;
   localparam int OFS_PTR  = 1;
   localparam int OFS_TEST = 2;
   localparam int OFS_MASK = 3;

   // Per-channel register indexes behind the data port
   localparam int IX_CMD  = 0;
   localparam int IX_GEN  = 1;
   localparam int IX_RALO = 2;
   localparam int IX_RAHI = 3;
   localparam int IX_CTL  = 4;
   localparam int IX_DTIM = 5;
   localparam int IX_CTIM = 6;

   // Pointer byte fields
   localparam int PTR_AUTO_BIT = 7;
   localparam int PTR_CHAN_BIT = 3;

   // Bit positions inside the read-ahead upper register
   localparam int RAHI_EN_BIT  = 7;
   localparam int RAHI_CLR_BIT = 6;

   typedef struct packed {
      logic dma_en;
      logic dev_rst;
      logic iordy_en;
      logic port8;
      logic act_low;
      logic pwr_save;
      logic bm_mode;
      logic io_en;
   } gen_cfg_t;
endpackage

// File: rtl/ipd_pointer.sv
module ipd_pointer #(
   parameter int PTR_W    = 8,
   parameter int IDX_W    = 3,
   parameter int LAST_IDX = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_we,
   input  logic [PTR_W-1:0] ptr_wdata,
   input  logic             data_acc,
   output logic [PTR_W-1:0] ptr_q
);
   import ipd_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

   if (PTR_W <= PTR_AUTO_BIT) begin : g_bad_ptr_w
      $error("ipd_pointer: PTR_W too small for auto-advance bit");
   end
   if (LAST_IDX >= (1 << IDX_W)) begin : g_bad_last
      $error("ipd_pointer: LAST_IDX does not fit in IDX_W bits");
   end

   logic [IDX_W-1:0] idx_next;

   always_comb begin
      if (ptr_q[IDX_W-1:0] >= LAST) idx_next = '0;
      else                          idx_next = ptr_q[IDX_W-1:0] + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ptr_we) begin
         ptr_q <= ptr_wdata;
      end else if (data_acc && ptr_q[PTR_AUTO_BIT]) begin
         ptr_q[IDX_W-1:0] <= idx_next;
      end
   end
endmodule

// File: rtl/ipd_chan_bank.sv
module ipd_chan_bank #(
   parameter int                DATA_W   = 16,
   parameter int                BYTE_W   = 8,
   parameter int                IDX_W    = 3,
   parameter int                RA_W     = 10,
   parameter logic [DATA_W-1:0] CMD_RST  = 16'h01F0,
   parameter logic [DATA_W-1:0] CTL_RST  = 16'h03F6,
   parameter logic [BYTE_W-1:0] GEN_RST  = 8'h01,
   parameter logic [BYTE_W-1:0] DTIM_RST = 8'hF5,
   parameter logic [BYTE_W-1:0] CTIM_RST = 8'hDE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] cmd_base,
   output logic [DATA_W-1:0] ctl_base,
   output logic [BYTE_W-1:0] gen_cfg,
   output logic [BYTE_W-1:0] dtim,
   output logic [BYTE_W-1:0] ctim,
   output logic [RA_W-1:0]   ra_count,
   output logic              ra_en,
   output logic              fifo_clr
);
   import ipd_pkg::*;

   localparam int RA_HI_W = RA_W - BYTE_W;

   if (RA_HI_W < 1 || RA_HI_W > RAHI_CLR_BIT) begin : g_bad_ra_w
      $error("ipd_chan_bank: RA_W must leave 1..6 upper count bits");
   end
   if (DATA_W < BYTE_W) begin : g_bad_data_w
      $error("ipd_chan_bank: DATA_W narrower than BYTE_W");
   end

   logic [DATA_W-1:0]  cmd_q, ctl_q;
   logic [BYTE_W-1:0]  gen_q, dtim_q, ctim_q, ralo_q;
   logic [RA_HI_W-1:0] rahi_q;
   logic               raen_q, clr_q;

   logic hit_cmd, hit_gen, hit_ralo, hit_rahi, hit_ctl, hit_dtim, hit_ctim;

   assign hit_cmd  = (idx == IDX_W'(IX_CMD));
   assign hit_gen  = (idx == IDX_W'(IX_GEN));
   assign hit_ralo = (idx == IDX_W'(IX_RALO));
   assign hit_rahi = (idx == IDX_W'(IX_RAHI));
   assign hit_ctl  = (idx == IDX_W'(IX_CTL));
   assign hit_dtim = (idx == IDX_W'(IX_DTIM));
   assign hit_ctim = (idx == IDX_W'(IX_CTIM));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_RST;
         ctl_q  <= CTL_RST;
         gen_q  <= GEN_RST;
         dtim_q <= DTIM_RST;
         ctim_q <= CTIM_RST;
         ralo_q <= '0;
         rahi_q <= '0;
         raen_q <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= we && hit_rahi && wdata[RAHI_CLR_BIT];
         if (we) begin
            if (hit_cmd)  cmd_q  <= wdata;
            if (hit_ctl)  ctl_q  <= wdata;
            if (hit_gen)  gen_q  <= wdata[BYTE_W-1:0];
            if (hit_dtim) dtim_q <= wdata[BYTE_W-1:0];
            if (hit_ctim) ctim_q <= wdata[BYTE_W-1:0];
            if (hit_ralo) ralo_q <= wdata[BYTE_W-1:0];
            if (hit_rahi) begin
               rahi_q <= wdata[RA_HI_W-1:0];
               raen_q <= wdata[RAHI_EN_BIT];
            end
         end
      end
   end

   // Read-ahead registers are write-only; index 7 is empty
   always_comb begin
      rd_data = '0;
      if (hit_cmd)  rd_data = cmd_q;
      if (hit_ctl)  rd_data = ctl_q;
      if (hit_gen)  rd_data = DATA_W'(gen_q);
      if (hit_dtim) rd_data = DATA_W'(dtim_q);
      if (hit_ctim) rd_data = DATA_W'(ctim_q);
   end

   assign cmd_base = cmd_q;
   assign ctl_base = ctl_q;
   assign gen_cfg  = gen_q;
   assign dtim     = dtim_q;
   assign ctim     = ctim_q;
   assign ra_count = {rahi_q, ralo_q};
   assign ra_en    = raen_q;
   assign fifo_clr = clr_q;
endmodule

// File: rtl/ipd_irq_ctl.sv
module ipd_irq_ctl #(
   parameter int NUM_CH = 2,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_we,
   input  logic              mask_we,
   input  logic [1:0]        wbits,
   input  logic [NUM_CH-1:0] drv_irq,
   input  logic [NUM_CH-1:0] bm_irq,
   input  logic [NUM_CH-1:0] act_low,
   input  logic              legacy_hdr,
   output logic [BYTE_W-1:0] status_rd,
   output logic [BYTE_W-1:0] mask_rd,
   output logic [NUM_CH-1:0] mask_q,
   output logic              test_mode,
   output logic              legacy_mode,
   output logic [NUM_CH-1:0] irq_out
);
   if (NUM_CH != 2) begin : g_bad_ch
      $error("ipd_irq_ctl: status and mask layout needs exactly two channels");
   end
   if (BYTE_W < 5) begin : g_bad_byte
      $error("ipd_irq_ctl: BYTE_W too narrow for the mask byte");
   end

   logic [1:0] test_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         test_q <= '0;
         mask_q <= '0;
      end else begin
         if (test_we) test_q <= wbits;
         if (mask_we) mask_q <= wbits[NUM_CH-1:0];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
      assign irq_out[c] = ((drv_irq[c] | bm_irq[c]) & ~mask_q[c]) ^ act_low[c];
   end

   assign status_rd   = BYTE_W'({bm_irq[0], drv_irq[0]});
   assign mask_rd     = BYTE_W'({legacy_hdr, bm_irq[1], drv_irq[1], mask_q[1], mask_q[0]});
   assign test_mode   = test_q[0];
   assign legacy_mode = test_q[1];
endmodule

// File: rtl/ipd_cfg_bank.sv
module ipd_cfg_bank #(
   parameter int                NUM_CH    = 2,
   parameter int                DATA_W    = 16,
   parameter int                BYTE_W    = 8,
   parameter int                IDX_W     = 3,
   parameter int                LAST_IDX  = 6,
   parameter int                RA_W      = 10,
   parameter logic [DATA_W-1:0] CMD_RST0  = 16'h01F0,
   parameter logic [DATA_W-1:0] CMD_RST1  = 16'h0170,
   parameter logic [DATA_W-1:0] CTL_RST0  = 16'h03F6,
   parameter logic [DATA_W-1:0] CTL_RST1  = 16'h0376,
   parameter logic [BYTE_W-1:0] GEN_RST   = 8'h01,
   parameter logic [BYTE_W-1:0] DTIM_RST  = 8'hF5,
   parameter logic [BYTE_W-1:0] CTIM_RST  = 8'hDE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_wr,
   input  logic                     host_rd,
   input  logic [1:0]               host_addr,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic [DATA_W-1:0]        host_rdata,
   input  logic                     legacy_hdr_i,
   input  logic [NUM_CH-1:0]        drv_irq_i,
   input  logic [NUM_CH-1:0]        bm_irq_i,
   output logic [NUM_CH*DATA_W-1:0] cmd_base_o,
   output logic [NUM_CH*DATA_W-1:0] ctl_base_o,
   output logic [NUM_CH*BYTE_W-1:0] data_tim_o,
   output logic [NUM_CH*BYTE_W-1:0] cmd_tim_o,
   output logic [NUM_CH-1:0]        dma_en_o,
   output logic [NUM_CH-1:0]        dev_rst_o,
   output logic [NUM_CH-1:0]        iordy_en_o,
   output logic [NUM_CH-1:0]        port8_o,
   output logic [NUM_CH-1:0]        irq_act_low_o,
   output logic [NUM_CH-1:0]        pwr_save_o,
   output logic [NUM_CH-1:0]        bm_mode_o,
   output logic [NUM_CH-1:0]        io_en_o,
   output logic [NUM_CH*RA_W-1:0]   ra_count_o,
   output logic [NUM_CH-1:0]        ra_en_o,
   output logic [NUM_CH-1:0]        fifo_clr_o,
   output logic                     test_mode_o,
   output logic                     legacy_mode_o,
   output logic [NUM_CH-1:0]        irq_o
);
   import ipd_pkg::*;

   localparam int PTR_W = BYTE_W;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("ipd_cfg_bank: one pointer bit selects the bank, so NUM_CH must be 2");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("ipd_cfg_bank: pointer layout needs an 8-bit byte");
   end

   logic [PTR_W-1:0]  ptr_q;
   logic [NUM_CH-1:0] irq_mask;
   logic              acc_wr, acc_rd, data_acc, chan_sel;
   logic [BYTE_W-1:0] status_rd, mask_rd;
   logic [DATA_W-1:0] bank_rd [NUM_CH];
   gen_cfg_t          gen_cfg [NUM_CH];

   assign acc_wr   = host_wr;
   assign acc_rd   = host_rd & ~host_wr;
   assign data_acc = (acc_wr | acc_rd) && (host_addr == 2'(OFS_DATA));
   assign chan_sel = ptr_q[PTR_CHAN_BIT];

   ipd_pointer #(
      .PTR_W    (PTR_W),
      .IDX_W    (IDX_W),
      .LAST_IDX (LAST_IDX)
   ) i_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_we    (acc_wr && host_addr == 2'(OFS_PTR)),
      .ptr_wdata (host_wdata[PTR_W-1:0]),
      .data_acc  (data_acc),
      .ptr_q     (ptr_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
      logic [BYTE_W-1:0] gen_raw;

      ipd_chan_bank #(
         .DATA_W   (DATA_W),
         .BYTE_W   (BYTE_W),
         .IDX_W    (IDX_W),
         .RA_W     (RA_W),
         .CMD_RST  ((c == 0) ? CMD_RST0 : CMD_RST1),
         .CTL_RST  ((c == 0) ? CTL_RST0 : CTL_RST1),
         .GEN_RST  (GEN_RST),
         .DTIM_RST (DTIM_RST),
         .CTIM_RST (CTIM_RST)
      ) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (acc_wr && host_addr == 2'(OFS_DATA) && chan_sel == 1'(c)),
         .idx      (ptr_q[IDX_W-1:0]),
         .wdata    (host_wdata),
         .rd_data  (bank_rd[c]),
         .cmd_base (cmd_base_o[c*DATA_W +: DATA_W]),
         .ctl_base (ctl_base_o[c*DATA_W +: DATA_W]),
         .gen_cfg  (gen_raw),
         .dtim     (data_tim_o[c*BYTE_W +: BYTE_W]),
         .ctim     (cmd_tim_o[c*BYTE_W +: BYTE_W]),
         .ra_count (ra_count_o[c*RA_W +: RA_W]),
         .ra_en    (ra_en_o[c]),
         .fifo_clr (fifo_clr_o[c])
      );

      assign gen_cfg[c]       = gen_cfg_t'(gen_raw);
      assign dma_en_o[c]      = gen_cfg[c].dma_en;
      assign dev_rst_o[c]     = gen_cfg[c].dev_rst;
      assign iordy_en_o[c]    = gen_cfg[c].iordy_en;
      assign port8_o[c]       = gen_cfg[c].port8;
      assign irq_act_low_o[c] = gen_cfg[c].act_low;
      assign pwr_save_o[c]    = gen_cfg[c].pwr_save;
      assign bm_mode_o[c]     = gen_cfg[c].bm_mode;
      assign io_en_o[c]       = gen_cfg[c].io_en;
   end

   ipd_irq_ctl #(
      .NUM_CH (NUM_CH),
      .BYTE_W (BYTE_W)
   ) i_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_we     (acc_wr && host_addr == 2'(OFS_TEST)),
      .mask_we     (acc_wr && host_addr == 2'(OFS_MASK)),
      .wbits       (host_wdata[1:0]),
      .drv_irq     (drv_irq_i),
      .bm_irq      (bm_irq_i),
      .act_low     (irq_act_low_o),
      .legacy_hdr  (legacy_hdr_i),
      .status_rd   (status_rd),
      .mask_rd     (mask_rd),
      .mask_q      (irq_mask),
      .test_mode   (test_mode_o),
      .legacy_mode (legacy_mode_o),
      .irq_out     (irq_o)
   );

   always_comb begin
      host_rdata = '0;
      if (acc_rd) begin
         case (host_addr)
            2'(OFS_DATA): host_rdata = bank_rd[chan_sel];
            2'(OFS_PTR):  host_rdata = DATA_W'(ptr_q);
            2'(OFS_TEST): host_rdata = DATA_W'(status_rd);
            default:      host_rdata = DATA_W'(mask_rd);
         endcase
      end
   end
endmodule

// File: rtl/ipd_cfg_bank_chk.sv
module ipd_cfg_bank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        host_wr,
   input logic        host_rd,
   input logic [1:0]  host_addr,
   input logic [15:0] host_wdata,
   input logic [15:0] host_rdata,
   input logic [7:0]  ptr,
   input logic [1:0]  mask,
   input logic [1:0]  act_low,
   input logic [1:0]  irq,
   input logic [1:0]  drv_irq,
   input logic [1:0]  bm_irq,
   input logic [1:0]  fifo_clr
);
   logic acc, rd_only;
   assign rd_only = host_rd && !host_wr;
   assign acc     = (host_wr || host_rd) && host_addr == 2'd0;

   AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ptr[7] && ptr[2:0] >= 3'd6) |=> (ptr[2:0] == 3'd0)); // R5
   AST_UPPER_PTR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (ptr[7:3] == $past(ptr[7:3]))); // R5
   AST_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ptr[7]) |=> $stable(ptr)); // R5
   AST_UNREADABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && host_addr == 2'd0 &&
       (ptr[2:0] == 3'd2 || ptr[2:0] == 3'd3 || ptr[2:0] == 3'd7)) |-> (host_rdata == 16'h0)); // R4
   AST_FIFO_PULSE0: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr[0] |-> $past(host_wr && host_addr == 2'd0 && ptr[3:0] == 4'h3 && host_wdata[6])); // R7
   AST_FIFO_PULSE1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr[1] |-> $past(host_wr && host_addr == 2'd0 && ptr[3:0] == 4'hB && host_wdata[6])); // R7
   AST_MASK_GATES0: assert property (@(posedge clk) disable iff (!rst_n)
      mask[0] |-> (irq[0] == act_low[0])); // R10
   AST_MASK_GATES1: assert property (@(posedge clk) disable iff (!rst_n)
      mask[1] |-> (irq[1] == act_low[1])); // R10
   AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && host_addr == 2'd2) |-> (host_rdata == {14'h0, bm_irq[0], drv_irq[0]})); // R9
endmodule

bind ipd_cfg_bank ipd_cfg_bank_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .ptr        (ptr_q),
   .mask       (irq_mask),
   .act_low    (irq_act_low_o),
   .irq        (irq_o),
   .drv_irq    (drv_irq_i),
   .bm_irq     (bm_irq_i),
   .fifo_clr   (fifo_clr_o)
);

// File: tb/test_ipd_cfg_bank.sv
module test_ipd_cfg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [15:0] host_wdata = 16'h0;
   logic [15:0] host_rdata;
   logic        legacy_hdr_i = 1'b0;
   logic [1:0]  drv_irq_i = 2'b00, bm_irq_i = 2'b00;
   logic [31:0] cmd_base_o, ctl_base_o;
   logic [15:0] data_tim_o, cmd_tim_o;
   logic [1:0]  dma_en_o, dev_rst_o, iordy_en_o, port8_o, irq_act_low_o;
   logic [1:0]  pwr_save_o, bm_mode_o, io_en_o, ra_en_o, fifo_clr_o, irq_o;
   logic [19:0] ra_count_o;
   logic        test_mode_o, legacy_mode_o;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ipd_cfg_bank i_ipd_cfg_bank (.*);

   // Behavioural reference state
   logic [15:0] m_cmd [2], m_ctl [2];
   logic [7:0]  m_gen [2], m_dtim [2], m_ctim [2], m_ralo [2];
   logic [1:0]  m_rahi [2];
   logic        m_raen [2], m_clr [2];
   logic [7:0]  m_ptr;
   logic [1:0]  m_mask, m_test;

   task automatic model_reset();
      m_cmd[0] = 16'h01F0; m_cmd[1] = 16'h0170;
      m_ctl[0] = 16'h03F6; m_ctl[1] = 16'h0376;
      for (int c = 0; c < 2; c++) begin
         m_gen[c] = 8'h01; m_dtim[c] = 8'hF5; m_ctim[c] = 8'hDE;
         m_ralo[c] = 8'h00; m_rahi[c] = 2'b00; m_raen[c] = 1'b0; m_clr[c] = 1'b0;
      end
      m_ptr = 8'h00; m_mask = 2'b00; m_test = 2'b00;
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rdata();
      int c, i;
      if (!host_rd || host_wr) return 16'h0;
      c = int'(m_ptr[3]);
      i = int'(m_ptr[2:0]);
      case (host_addr)
         2'd0: case (i)
                  0: return m_cmd[c];
                  1: return {8'h0, m_gen[c]};
                  4: return m_ctl[c];
                  5: return {8'h0, m_dtim[c]};
                  6: return {8'h0, m_ctim[c]};
                  default: return 16'h0;
               endcase
         2'd1: return {8'h0, m_ptr};
         2'd2: return {14'h0, bm_irq_i[0], drv_irq_i[0]};
         default: return {11'h0, legacy_hdr_i, bm_irq_i[1], drv_irq_i[1], m_mask};
      endcase
   endfunction

   task automatic compare_all();
      string rtag;
      logic [1:0] e_irq;
      case (host_addr)
         2'd0: rtag = (m_ptr[2:0] == 3'd2 || m_ptr[2:0] == 3'd3 || m_ptr[2:0] == 3'd7) ? "R4" : "R3";
         2'd1: rtag = "R2";
         default: rtag = "R9";
      endcase
      chk(rtag, "host_rdata", 32'(host_rdata), 32'(exp_rdata()));
      chk("R3", "cmd_base", cmd_base_o, {m_cmd[1], m_cmd[0]});
      chk("R3", "ctl_base", ctl_base_o, {m_ctl[1], m_ctl[0]});
      chk("R3", "timing", {data_tim_o, cmd_tim_o}, {m_dtim[1], m_dtim[0], m_ctim[1], m_ctim[0]});
      chk("R8", "gen fields",
          {16'h0, dma_en_o, dev_rst_o, iordy_en_o, port8_o, irq_act_low_o, pwr_save_o, bm_mode_o, io_en_o},
          {16'h0, m_gen[1][7], m_gen[0][7], m_gen[1][6], m_gen[0][6], m_gen[1][5], m_gen[0][5],
           m_gen[1][4], m_gen[0][4], m_gen[1][3], m_gen[0][3], m_gen[1][2], m_gen[0][2],
           m_gen[1][1], m_gen[0][1], m_gen[1][0], m_gen[0][0]});
      chk("R6", "read-ahead", {10'h0, ra_count_o, ra_en_o},
          {10'h0, m_rahi[1], m_ralo[1], m_rahi[0], m_ralo[0], m_raen[1], m_raen[0]});
      chk("R7", "fifo_clr", 32'(fifo_clr_o), 32'({m_clr[1], m_clr[0]}));
      chk("R11", "test bits", 32'({legacy_mode_o, test_mode_o}), 32'(m_test));
      for (int c = 0; c < 2; c++)
         e_irq[c] = ((drv_irq_i[c] | bm_irq_i[c]) & ~m_mask[c]) ^ m_gen[c][3];
      chk("R10", "irq_o", 32'(irq_o), 32'(e_irq));
   endtask

   task automatic model_update();
      int c, i;
      c = int'(m_ptr[3]);
      i = int'(m_ptr[2:0]);
      m_clr[0] = 1'b0; m_clr[1] = 1'b0;
      if (host_wr) begin
         case (host_addr)
            2'd0: begin
               case (i)
                  0: m_cmd[c] = host_wdata;
                  1: m_gen[c] = host_wdata[7:0];
                  2: m_ralo[c] = host_wdata[7:0];
                  3: begin m_rahi[c] = host_wdata[1:0]; m_raen[c] = host_wdata[7]; m_clr[c] = host_wdata[6]; end
                  4: m_ctl[c] = host_wdata;
                  5: m_dtim[c] = host_wdata[7:0];
                  6: m_ctim[c] = host_wdata[7:0];
                  default: ;
               endcase
               if (m_ptr[7]) m_ptr[2:0] = (i >= 6) ? 3'd0 : 3'(i + 1);
            end
            2'd1: m_ptr = host_wdata[7:0];
            2'd2: m_test = host_wdata[1:0];
            default: m_mask = host_wdata[1:0];
         endcase
      end else if (host_rd && host_addr == 2'd0 && m_ptr[7]) begin
         m_ptr[2:0] = (i >= 6) ? 3'd0 : 3'(i + 1);
      end
   endtask

   // One host cycle; called at a falling edge
   task automatic step(input logic w, input logic r, input logic [1:0] a, input logic [15:0] d);
      host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
      #2 compare_all();
      @(posedge clk);
      #1 model_update();
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d); step(1'b1, 1'b0, a, d); endtask
   task automatic rd(input logic [1:0] a); step(1'b0, 1'b1, a, 16'h0); endtask

   task automatic expect_ptr(input logic [7:0] exp);
      host_rd = 1'b1; host_addr = 2'd1;
      #2 chk("R5", "pointer after accesses", 32'(host_rdata), 32'(exp));
      @(posedge clk);
      #1 model_update();
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: literal reset values
      chk("R1", "cmd_base reset", cmd_base_o, 32'h0170_01F0);
      chk("R1", "ctl_base reset", ctl_base_o, 32'h0376_03F6);
      chk("R1", "timing reset", {data_tim_o, cmd_tim_o}, 32'hF5F5_DEDE);
      chk("R1", "io_en reset", 32'({io_en_o, dma_en_o, ra_en_o, irq_o}), 32'h0C0);
      chk("R1", "ra_count reset", 32'(ra_count_o), 32'h0);
      rd(2'd1);
      rd(2'd3);

      // R5: sweep channel 0 with auto-advance, wrap 6 -> 0
      wr(2'd1, 16'h0080);
      for (int k = 0; k < 8; k++) rd(2'd0);
      expect_ptr(8'h81);
      // Sweep channel 1
      wr(2'd1, 16'h0088);
      for (int k = 0; k < 7; k++) rd(2'd0);
      expect_ptr(8'h88);

      // R3/R6/R7/R8: write sweep of channel 0
      wr(2'd1, 16'h0080);
      wr(2'd0, 16'hAAAA);
      wr(2'd0, 16'h12F9);
      wr(2'd0, 16'h005A);
      wr(2'd0, 16'h00C3);
      wr(2'd0, 16'h1234);
      wr(2'd0, 16'h0009);
      wr(2'd0, 16'h0000);
      expect_ptr(8'h80);
      // Write sweep of channel 1 with other data
      wr(2'd1, 16'h0088);
      wr(2'd0, 16'h5555);
      wr(2'd0, 16'h0006);
      wr(2'd0, 16'h00FF);
      wr(2'd0, 16'h0042);
      wr(2'd0, 16'hFEDC);
      wr(2'd0, 16'h0033);
      wr(2'd0, 16'h00CC);
      // Read both banks back
      wr(2'd1, 16'h0080);
      for (int k = 0; k < 7; k++) rd(2'd0);
      wr(2'd1, 16'h0088);
      for (int k = 0; k < 7; k++) rd(2'd0);

      // R5: no auto-advance keeps the index
      wr(2'd1, 16'h0008);
      wr(2'd0, 16'h1357);
      rd(2'd0);
      rd(2'd0);
      expect_ptr(8'h08);

      // R4: index 7 write ignored, reads of 2, 3, 7 give zero
      wr(2'd1, 16'h0007);
      wr(2'd0, 16'hFFFF);
      rd(2'd0);
      wr(2'd1, 16'h0002); rd(2'd0);
      wr(2'd1, 16'h0003); rd(2'd0);
      wr(2'd1, 16'h0087); rd(2'd0);
      expect_ptr(8'h80);
      // Back-to-back FIFO clear writes on channel 1 (R7)
      wr(2'd1, 16'h000B);
      wr(2'd0, 16'h0040);
      wr(2'd0, 16'h0040);
      wr(2'd0, 16'h0001);

      // R11: test register and status isolation
      wr(2'd2, 16'h0083);
      rd(2'd2);
      wr(2'd2, 16'h0001);
      rd(2'd2);

      // R9/R10: interrupts under every mask, polarity and raw pattern
      for (int pol = 0; pol < 4; pol++) begin
         wr(2'd1, 16'h0001); wr(2'd0, 16'(pol[0] ? 8'h09 : 8'h01));
         wr(2'd1, 16'h0009); wr(2'd0, 16'(pol[1] ? 8'h0E : 8'h06));
         for (int mk = 0; mk < 4; mk++) begin
            wr(2'd3, 16'(16'hFFFC | mk));
            for (int p = 0; p < 16; p++) begin
               drv_irq_i = p[1:0];
               bm_irq_i = p[3:2];
               legacy_hdr_i = p[0] ^ p[3];
               rd(2'd2);
               rd(2'd3);
            end
         end
      end
      drv_irq_i = 2'b00; bm_irq_i = 2'b00;
      step(1'b0, 1'b0, 2'd0, 16'h0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule